// File: doc/BRIEF.md
# RMII Ethernet Frame Transmitter

This block turns a stream of frame bytes into the 2-bit transmit bus of a reduced media-independent interface, running at 100 Mbit/s on a 50 MHz reference clock. It is meant for a direct MAC-to-MAC link with no PHY in between. The user side presents the destination address, source address, type/length field and payload as a byte stream with valid, data and last signals. The block answers with ready. The block adds the preamble and start delimiter, pads short frames, and computes and appends the frame check sequence. It then holds off the next frame for the inter-frame gap.

A frame starts when valid is seen while the block is idle. Bytes are then taken one at a time, once per byte slot of four clocks. Ready is high for exactly the one clock in which the next byte is needed. If valid is low at that moment, the data part of the frame ends there and the frame is padded and closed as normal. A source that reaches the largest allowed frame without marking the last byte gets its frame closed at that size, and the block signals an error.

Top module: `rmii_frame_tx`

## Requirements
- R1: After reset, line_en is 0, line_d is 00, in_ready is 0 and frame_err is 0.
- R2: Every frame starts on the line with seven 0x55 bytes followed by one 0xD5 byte. Each byte is sent as four dibits on consecutive clocks, bits [1:0] first and bits [7:6] last, with line_d[0] carrying the lower bit of each pair. The wire bit order is therefore least significant bit first.
- R3: The accepted user bytes follow the 0xD5 byte unchanged and in acceptance order. A 16-bit type/length field supplied high byte first therefore leaves high byte first.
- R4: When fewer than 60 bytes (14 header bytes plus 46 payload bytes) were accepted, bytes of 0x00 are added until the data part holds 60 bytes. Longer frames get no padding.
- R5: The data part (accepted bytes plus padding) is followed by four check bytes. They are the complement of a CRC-32 with reflected polynomial 0xEDB88320, preset to 0xFFFFFFFF and updated over the data part least significant bit first, and they are sent least significant byte first. A CRC over the data part and the check bytes leaves the register at 0xDEBB20E3.
- R6: line_en stays high without a break from the first preamble dibit to the last check dibit, for exactly 4 × (8 + data bytes + 4) clocks.
- R7: Between the end of one frame and the start of the next, line_en stays low for at least 48 clocks (96 bit times).
- R8: in_ready is high only while line_en is high, in the last clock of the 0xD5 byte or of a data byte, and only while more user bytes are wanted. It is never high during the first seven preamble bytes, padding, check bytes, the gap or idle. One byte is accepted per clock in which in_valid and in_ready are both high.
- R9: When the 1514th byte is accepted without in_last, no further bytes are taken and the frame is closed with its check bytes. frame_err pulses high for one clock. frame_err stays low for every frame that ends with in_last at or below 1514 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz transmit reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is offered |
| in_data | input | 8 | Offered frame byte |
| in_last | input | 1 | Offered byte is the final user byte of the frame |
| in_ready | output | 1 | Block takes the offered byte this clock |
| line_en | output | 1 | Transmit enable on the line |
| line_d | output | 2 | Transmit dibit, bit 0 is the earlier bit |
| frame_err | output | 1 | One-clock pulse when a frame is cut at the maximum length |

## Verification
A wrong byte counter in the preamble, padding or gap sequencing shows up directly as a frame of the wrong length, or as a gap that is too short. Both are visible on line_en within the same frame. A CRC register that picks up a wrong byte, or misses one, cannot be seen until the four check bytes at the end of that frame. Sweeping the payload length across the padding threshold in single steps exposes any off-by-one error there. A faulty ready window shows as a byte accepted in the wrong slot, which corrupts the data bytes that follow in that same frame.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

  // Byte-wide update of the reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc32_next(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  // Check byte number idx (0 goes first) taken from the CRC register.
  function automatic logic [7:0] fcs_byte(input logic [31:0] c, input logic [1:0] idx);
    logic [31:0] inv;
    inv = ~c;
    return inv[{idx, 3'b000} +: 8];
  endfunction

  // Dibit for phase ph of a byte, bits [1:0] at phase 0.
  function automatic logic [1:0] dibit_of(input logic [7:0] b, input logic [1:0] ph);
    return b[{ph, 1'b0} +: 2];
  endfunction

endpackage

// File: rtl/rmii_tx_crc.sv
module rmii_tx_crc
  import rmii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_PRESET;
    else if (clr_i) crc_q <= CRC_PRESET;
    else if (en_i)  crc_q <= crc32_next(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  // R5
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == CRC_PRESET));

endmodule

// File: rtl/rmii_tx_dibit.sv
module rmii_tx_dibit
  import rmii_tx_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [1:0] phase_i,
  input  logic       active_i,
  output logic [1:0] d_o
);

  always_comb begin
    d_o = active_i ? dibit_of(byte_i, phase_i) : 2'b00;
  end

endmodule

// File: rtl/rmii_tx_ctrl.sv
module rmii_tx_ctrl
  import rmii_tx_pkg::*;
#(
  parameter int PRE_LEN   = 7,
  parameter int MIN_LEN   = 60,
  parameter int MAX_LEN   = 1514,
  parameter int GAP_BYTES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  input  logic [31:0] crc_i,
  output logic        crc_clr,
  output logic        crc_en,
  output logic [7:0]  crc_byte,
  output logic [7:0]  cur_byte_o,
  output logic [1:0]  phase_o,
  output logic        active_o,
  output logic        err_o
);

  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] PRE_M1 = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0] PRE_SF = CW'(PRE_LEN);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_LEN);
  localparam logic [CW-1:0] MAX_M1 = CW'(MAX_LEN - 1);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP_BYTES - 1);

  tx_state_e     state;
  logic [1:0]    ph;
  logic [CW-1:0] bcnt;
  logic [CW-1:0] dcnt;
  logic [7:0]    cur;
  logic          done_data;
  logic          err_q;

  // Named internal events
  logic byte_end, start, in_fetch, use_data, pad_next, fcs_next, hit_max;

  assign byte_end = (state != ST_IDLE) && (ph == 2'd3);
  assign start    = (state == ST_IDLE) && s_valid;
  assign in_fetch = byte_end && ((state == ST_PRE && bcnt == PRE_SF) ||
                                 state == ST_DATA || state == ST_PAD);
  assign s_ready  = byte_end && !done_data &&
                    ((state == ST_PRE && bcnt == PRE_SF) || state == ST_DATA);
  assign use_data = s_ready && s_valid;
  assign pad_next = in_fetch && !use_data && (dcnt < MIN_C);
  assign fcs_next = in_fetch && !use_data && !(dcnt < MIN_C);
  assign hit_max  = use_data && !s_last && (dcnt == MAX_M1);

  assign crc_clr  = start;
  assign crc_en   = use_data || pad_next;
  assign crc_byte = use_data ? s_data : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ph        <= 2'd0;
      bcnt      <= '0;
      dcnt      <= '0;
      cur       <= 8'h00;
      done_data <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= hit_max;
      if (state != ST_IDLE) ph <= ph + 2'd1;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_PRE;
          bcnt      <= '0;
          cur       <= PRE_BYTE;
          dcnt      <= '0;
          done_data <= 1'b0;
        end
        ST_PRE: if (byte_end) begin
          if (bcnt == PRE_M1) begin
            cur  <= SFD_BYTE;
            bcnt <= bcnt + 1'b1;
          end else if (bcnt < PRE_M1) begin
            cur  <= PRE_BYTE;
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_FCS: if (byte_end) begin
          if (bcnt[1:0] == 2'd3) begin
            state <= ST_GAP;
            bcnt  <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
            cur  <= fcs_byte(crc_i, bcnt[1:0] + 2'd1);
          end
        end
        ST_GAP: if (byte_end) begin
          if (bcnt == GAP_M1) state <= ST_IDLE;
          else                bcnt  <= bcnt + 1'b1;
        end
        default: ;
      endcase
      if (use_data) begin
        state     <= ST_DATA;
        cur       <= s_data;
        dcnt      <= dcnt + 1'b1;
        done_data <= s_last || hit_max;
      end else if (pad_next) begin
        state <= ST_PAD;
        cur   <= 8'h00;
        dcnt  <= dcnt + 1'b1;
      end else if (fcs_next) begin
        state <= ST_FCS;
        cur   <= fcs_byte(crc_i, 2'd0);
        bcnt  <= '0;
      end
    end
  end

  assign cur_byte_o = cur;
  assign phase_o    = ph;
  assign active_o   = (state == ST_PRE) || (state == ST_DATA) ||
                      (state == ST_PAD) || (state == ST_FCS);
  assign err_o      = err_q;

  // R8
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> active_o);

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAD) |-> (cur == 8'h00));

  // R4
  fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCS) |-> (dcnt >= MIN_C));

  // R5
  crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCS && $past(state == ST_FCS)) |-> $stable(crc_i));

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R9
  err_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (dcnt == CW'(MAX_LEN)));

endmodule

// File: rtl/rmii_frame_tx.sv
module rmii_frame_tx #(
  parameter int PRE_LEN   = 7,
  parameter int MIN_LEN   = 60,
  parameter int MAX_LEN   = 1514,
  parameter int GAP_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       line_en,
  output logic [1:0] line_d,
  output logic       frame_err
);

  localparam int GAP_CLK = GAP_BYTES * 4;
  localparam int MIN_RUN = (PRE_LEN + 1 + MIN_LEN + 4) * 4;

  logic [31:0] crc;
  logic        crc_clr, crc_en;
  logic [7:0]  crc_byte, cur_byte;
  logic [1:0]  phase;
  logic        active;

  rmii_tx_ctrl #(
    .PRE_LEN(PRE_LEN), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .GAP_BYTES(GAP_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_data(in_data), .s_last(in_last), .s_ready(in_ready),
    .crc_i(crc), .crc_clr(crc_clr), .crc_en(crc_en), .crc_byte(crc_byte),
    .cur_byte_o(cur_byte), .phase_o(phase), .active_o(active), .err_o(frame_err)
  );

  rmii_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr_i(crc_clr), .en_i(crc_en),
    .byte_i(crc_byte), .crc_o(crc)
  );

  rmii_tx_dibit u_dibit (
    .byte_i(cur_byte), .phase_i(phase), .active_i(active), .d_o(line_d)
  );

  assign line_en = active;

  // Run-length observers on the line for the timing assertions
  logic [15:0] low_cnt, high_cnt;
  logic        seen_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      high_cnt   <= '0;
      seen_frame <= 1'b0;
    end else if (line_en) begin
      low_cnt    <= '0;
      high_cnt   <= high_cnt + 16'd1;
      seen_frame <= 1'b1;
    end else begin
      high_cnt <= '0;
      if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
    end
  end

  // R7
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_en) && seen_frame) |-> (low_cnt >= 16'(GAP_CLK)));

  // R6
  txen_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_en) |-> (high_cnt[1:0] == 2'b00 && high_cnt >= 16'(MIN_RUN)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |-> (line_d == 2'b00 && !in_ready));

endmodule

// File: tb/rmii_frame_tx_tb.sv
module rmii_frame_tx_tb;

  localparam logic [31:0] POLY = 32'hEDB88320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0;
  logic in_ready, line_en, frame_err;
  logic [1:0] line_d;

  always #4 clk = ~clk;

  rmii_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .line_en(line_en),
    .line_d(line_d), .frame_err(frame_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] drv [0:2047];
  logic [7:0] expb[0:2047];
  logic [7:0] rx  [0:2047];
  int rxn = 0, kph = 0, hi_run = 0, last_hi = 0, low_run = 0;
  int frames_done = 0, bad_ready = 0, err_cnt = 0, cur_ndrive = 0;
  logic [7:0] acc = 8'h00;
  logic prev_en = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  // Line monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (in_ready && (!line_en || rxn < 7 || rxn >= 7 + cur_ndrive)) bad_ready++;
      if (frame_err) err_cnt++;
      if (line_en) begin
        if (!prev_en) begin
          if (frames_done > 0) check(low_run >= 48, "R7 gap clocks", low_run, 48);
          rxn = 0; kph = 0; hi_run = 0;
        end
        acc[2*kph +: 2] = line_d;
        kph++;
        if (kph == 4) begin
          rx[rxn] = acc;
          rxn++;
          kph = 0;
        end
        hi_run++;
      end else begin
        if (prev_en) begin
          frames_done++;
          last_hi = hi_run;
          low_run = 0;
        end
        low_run++;
      end
      prev_en = line_en;
    end
  end

  task automatic send_frame(input int npay, input bit overlong);
    int ndrive, ndata, target;
    logic [31:0] c;
    bit ok;
    ndrive = overlong ? 1514 : 14 + npay;
    for (int i = 0; i < 6; i++) drv[i] = (i == 0) ? 8'h02 : 8'(8'h10 + i);
    for (int i = 6; i < 12; i++) drv[i] = 8'(8'hA0 + i + npay);
    drv[12] = 8'h88;
    drv[13] = 8'hB5;
    for (int i = 14; i < ndrive; i++) drv[i] = 8'((i * 7 + npay * 13) & 255);
    ndata = (ndrive < 60) ? 60 : ndrive;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < ndata; i++) begin
      expb[i] = (i < ndrive) ? drv[i] : 8'h00;
      c = ref_crc(c, expb[i]);
    end
    for (int i = 0; i < 4; i++) expb[ndata + i] = 8'(~c >> (8 * i));
    cur_ndrive = ndrive;
    bad_ready = 0;
    err_cnt = 0;
    target = frames_done + 1;
    for (int j = 0; j < ndrive; j++) begin
      in_valid = 1'b1;
      in_data  = drv[j];
      in_last  = !overlong && (j == ndrive - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (frames_done < target) @(negedge clk);
    // R2 preamble and start byte
    ok = (rxn >= 8);
    for (int i = 0; i < 8 && i < rxn; i++)
      if (rx[i] != ((i == 7) ? 8'hD5 : 8'h55)) ok = 0;
    check(ok, "R2 preamble", int'(rx[7]), 8'hD5);
    // R4 total length with padding
    check(rxn == 8 + ndata + 4, "R4 frame bytes", rxn, 8 + ndata + 4);
    // R6 continuous enable
    check(last_hi == 4 * (8 + ndata + 4), "R6 enable clocks", last_hi, 4 * (8 + ndata + 4));
    // R3 user bytes in order
    ok = 1;
    for (int i = 0; i < ndrive; i++) if (rx[8 + i] !== drv[i]) ok = 0;
    check(ok, "R3 user bytes", int'(rx[8 + 12]), int'(drv[12]));
    // R4 pad bytes zero
    ok = 1;
    for (int i = ndrive; i < ndata; i++) if (rx[8 + i] !== 8'h00) ok = 0;
    check(ok, "R4 pad bytes", npay, npay);
    // R5 check bytes and residue
    ok = 1;
    for (int i = 0; i < 4; i++) if (rx[8 + ndata + i] !== expb[ndata + i]) ok = 0;
    check(ok, "R5 fcs", int'(rx[8 + ndata]), int'(expb[ndata]));
    c = 32'hFFFFFFFF;
    for (int i = 0; i < ndata + 4; i++) c = ref_crc(c, rx[8 + i]);
    check(c == 32'hDEBB20E3, "R5 residue", int'(c), int'(32'hDEBB20E3));
    check(bad_ready == 0, "R8 ready window", bad_ready, 0);
    check(err_cnt == (overlong ? 1 : 0), "R9 error pulses", err_cnt, overlong ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(line_en == 1'b0 && line_d == 2'b00, "R1 line idle", int'({line_en, line_d}), 0);
    check(in_ready == 1'b0 && frame_err == 1'b0, "R1 handshake idle",
          int'({in_ready, frame_err}), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int n = 0; n <= 50; n++) send_frame(n, 1'b0);
    send_frame(60, 1'b0);
    send_frame(100, 1'b0);
    send_frame(255, 1'b0);
    send_frame(1500, 1'b0);
    send_frame(0, 1'b1);
    send_frame(3, 1'b0);
    repeat (60) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule